// File: doc/BRIEF.md
# Exception Vector Catch Detector

This block watches the exception entries of a processor running in its 32-bit state. When the vector being taken has its catch enable set, it raises a debug event. Each entry arrives as a one-cycle strobe. The strobe carries the low byte offset of the vector within the table and the current security state. A 32-bit control word supplies the enable bits.

The offset is decoded to a vector slot. Offsets 0x04, 0x08, 0x0C, 0x10, 0x18 and 0x1C map to slots 1, 2, 3, 4, 6 and 7. Two enable banks exist when the security extension is built in:
- Secure state reads the low bank, bits 7:1.
- Non-secure state reads the high bank, bits 31:25. This bank uses the same slot order, and bit 29 is unused.

Without the security extension, the low bank is used whatever the security state. A match produces a registered one-cycle catch pulse together with the slot number of the vector that matched. Halting the core and address matching are handled elsewhere.

Top module: `exc_vector_catch`

## Requirements
- R1: While rst_ni is low, catch_o is 0 and catch_vec_o is 0.
- R2: A catch appears on catch_o exactly one clock edge after the sampled strobe and lasts one cycle. catch_o is high only in the cycle after a cycle in which entry_valid_i was high.
- R3: The slot number is offset/4. The enable bit in a bank is the slot number: 0x04→1 (undefined instruction), 0x08→2 (supervisor call), 0x0C→3 (prefetch abort), 0x10→4 (data abort), 0x18→6 (IRQ), 0x1C→7 (FIQ). On a catch, catch_vec_o takes the slot number.
- R4: With HAS_SECURITY=1 and secure_i=1, slot k is caught when catch_en_i[k] is 1.
- R5: With HAS_SECURITY=1 and secure_i=0, slot k is caught when catch_en_i[24+k] is 1. catch_en_i[29] never causes a catch, and in this state the low bank has no effect.
- R6: Offsets 0x00 and 0x14 are never caught, even when catch_en_i[0], catch_en_i[5] or catch_en_i[29] are set.
- R7: An offset whose two low bits are not 00, or an offset above 0x1C, never produces a catch.
- R8: With entry_valid_i low, no catch occurs, whatever the other inputs are.
- R9: catch_vec_o keeps its last value in every cycle in which catch_o is low.
- R10: With HAS_SECURITY=0, the low bank bits 7:1 are used for both values of secure_i, and bits 31:25 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_valid_i | input | 1 | Exception entry strobe |
| entry_offset_i | input | OFF_W | Byte offset of the vector within the table |
| secure_i | input | 1 | 1 = entry taken in secure state |
| catch_en_i | input | 32 | Catch enable control word |
| catch_o | output | 1 | One-cycle catch pulse |
| catch_vec_o | output | 3 | Slot number of the last caught vector |

## Verification
The hardest cases to reach are the unused positions. These are bit 29 in the non-secure bank, and bits 0 and 5 in the low bank. They must stay inert even when the offset that would index them arrives together with an all-ones enable word. The bench drives the offsets 0x00 and 0x14 with every enable bit set, in both security states. It also sets only the bank that the current state does not select. Two instances run on the same stimulus, one with and one without the security extension, so the bank that is read can be compared directly between them.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned SLOT_W   = 3;
  localparam int unsigned N_SLOTS  = 1 << SLOT_W;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned HI_BASE  = 24;
  // slots that own an enable bit: 1,2,3,4,6,7
  localparam logic [N_SLOTS-1:0] SLOT_MASK = 8'b1101_1110;
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/evc_offset_decode.sv
module evc_offset_decode
  import evc_pkg::*;
#(
  parameter int unsigned OFF_W = 8
) (
  input  logic [OFF_W-1:0]   offset_i,
  output logic               hit_o,
  output slot_t              slot_o,
  output logic [N_SLOTS-1:0] onehot_o
);
  localparam int unsigned SPAN = N_SLOTS * 4;

  logic aligned, in_range;

  always_comb begin
    aligned  = (offset_i[1:0] == 2'b00);
    in_range = ({{(32-OFF_W){1'b0}}, offset_i} < SPAN);
    slot_o   = offset_i[SLOT_W+1:2];
    hit_o    = aligned && in_range && SLOT_MASK[slot_o];
    onehot_o = '0;
    if (hit_o) onehot_o[slot_o] = 1'b1;
  end
endmodule

// File: rtl/evc_bank_select.sv
module evc_bank_select
  import evc_pkg::*;
#(
  parameter bit HAS_SECURITY = 1'b1
) (
  input  logic [CTRL_W-1:0]  en_i,
  input  logic               secure_i,
  output logic [N_SLOTS-1:0] bank_o
);
  logic [N_SLOTS-1:0] lo_bank, hi_bank;

  assign lo_bank = en_i[N_SLOTS-1:0] & SLOT_MASK;
  assign hi_bank = {en_i[HI_BASE+N_SLOTS-1:HI_BASE+1], 1'b0} & SLOT_MASK;

  generate
    if (HAS_SECURITY) begin : g_sec
      assign bank_o = secure_i ? lo_bank : hi_bank;
    end else begin : g_nosec
      logic unused_hi;
      assign unused_hi = ^hi_bank ^ secure_i;
      assign bank_o    = lo_bank;
    end
  endgenerate
endmodule

// File: rtl/exc_vector_catch.sv
module exc_vector_catch
  import evc_pkg::*;
#(
  parameter int unsigned OFF_W        = 8,
  parameter bit          HAS_SECURITY = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              entry_valid_i,
  input  logic [OFF_W-1:0]  entry_offset_i,
  input  logic              secure_i,
  input  logic [31:0]       catch_en_i,
  output logic              catch_o,
  output logic [2:0]        catch_vec_o
);
  logic               dec_hit;
  slot_t              dec_slot;
  logic [N_SLOTS-1:0] dec_onehot, bank;
  logic               match;

  evc_offset_decode #(.OFF_W(OFF_W)) u_dec (
    .offset_i (entry_offset_i),
    .hit_o    (dec_hit),
    .slot_o   (dec_slot),
    .onehot_o (dec_onehot)
  );

  evc_bank_select #(.HAS_SECURITY(HAS_SECURITY)) u_bank (
    .en_i     (catch_en_i),
    .secure_i (secure_i),
    .bank_o   (bank)
  );

  assign match = entry_valid_i && dec_hit && |(dec_onehot & bank);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      catch_o     <= 1'b0;
      catch_vec_o <= '0;
    end else begin
      catch_o <= match;
      if (match) catch_vec_o <= dec_slot;
    end
  end
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int unsigned OFF_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             entry_valid_i,
  input logic [OFF_W-1:0] entry_offset_i,
  input logic             secure_i,
  input logic [31:0]      catch_en_i,
  input logic             catch_o,
  input logic [2:0]       catch_vec_o
);
  assert_pulse_needs_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    catch_o |-> $past(entry_valid_i));

  assert_no_strobe_no_catch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry_valid_i |=> !catch_o);

  assert_unaligned_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_valid_i && entry_offset_i[1:0] != 2'b00) |=> !catch_o);

  assert_unowned_offsets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_valid_i && (entry_offset_i == 'h00 || entry_offset_i == 'h14)) |=> !catch_o);

  assert_slot_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    catch_o |-> (catch_vec_o != 3'd0 && catch_vec_o != 3'd5));

  assert_secure_svc_caught_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_valid_i && secure_i && entry_offset_i == 'h08 && catch_en_i[2]) |=> (catch_o && catch_vec_o == 3'd2));

  assert_vec_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !catch_o |-> $stable(catch_vec_o));
endmodule

bind exc_vector_catch evc_checker #(.OFF_W(OFF_W)) u_evc_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .entry_valid_i  (entry_valid_i),
  .entry_offset_i (entry_offset_i),
  .secure_i       (secure_i),
  .catch_en_i     (catch_en_i),
  .catch_o        (catch_o),
  .catch_vec_o    (catch_vec_o)
);

// File: tb/exc_vector_catch_test.sv
module exc_vector_catch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  off = '0;
  logic        sec = 1'b0;
  logic [31:0] en = '0;
  logic        catch_s, catch_n;
  logic [2:0]  vec_s, vec_n;
  logic [2:0]  exp_vec_s = '0, exp_vec_n = '0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  exc_vector_catch #(.OFF_W(8), .HAS_SECURITY(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .entry_valid_i(valid), .entry_offset_i(off),
    .secure_i(sec), .catch_en_i(en), .catch_o(catch_s), .catch_vec_o(vec_s));

  exc_vector_catch #(.OFF_W(8), .HAS_SECURITY(1'b0)) uut_nosec (
    .clk_i(clk), .rst_ni(rst_n), .entry_valid_i(valid), .entry_offset_i(off),
    .secure_i(sec), .catch_en_i(en), .catch_o(catch_n), .catch_vec_o(vec_n));

  function automatic bit model(input bit v, input logic [7:0] o, input bit s,
                               input logic [31:0] e, input bit has_sec);
    int k;
    if (!v || o[1:0] != 2'b00 || o > 8'h1C) return 1'b0;
    k = o >> 2;
    if (k == 0 || k == 5) return 1'b0;
    if (has_sec && !s) return e[24+k];
    return e[k];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one entry, sample both instances one edge later
  task automatic apply(input string req, input bit v, input logic [7:0] o,
                       input bit s, input logic [31:0] e);
    bit es, enn;
    @(negedge clk);
    valid = v; off = o; sec = s; en = e;
    es  = model(v, o, s, e, 1'b1);
    enn = model(v, o, s, e, 1'b0);
    if (es)  exp_vec_s = o[4:2];
    if (enn) exp_vec_n = o[4:2];
    @(negedge clk);
    valid = 1'b0;
    check({req, " catch sec"},   catch_s, es);
    check({req, " vec sec"},     vec_s,   exp_vec_s);
    check({req, " catch nosec"}, catch_n, enn);
    check({req, " vec nosec"},   vec_n,   exp_vec_n);
  endtask

  task automatic t_reset_R1();
    #1;
    check("R1 catch", catch_s, 0);
    check("R1 vec", vec_s, 0);
    check("R1 catch nosec", catch_n, 0);
  endtask

  task automatic t_pulse_R2();
    apply("R2", 1'b1, 8'h10, 1'b1, 32'h0000_0010);
    @(negedge clk);
    check("R2 one cycle", catch_s, 0);
    check("R2 one cycle nosec", catch_n, 0);
  endtask

  task automatic t_secure_map_R3_R4();
    for (int k = 1; k < 8; k++) begin
      if (k == 5) continue;
      apply("R3/R4 single", 1'b1, 8'(k*4), 1'b1, 32'(1) << k);
      apply("R4 others", 1'b1, 8'(k*4), 1'b1, ~(32'(1) << k));
    end
  endtask

  task automatic t_nonsecure_R5_R10();
    for (int k = 1; k < 8; k++) begin
      if (k == 5) continue;
      apply("R5 hi bank", 1'b1, 8'(k*4), 1'b0, 32'(1) << (24+k));
      apply("R10 lo bank", 1'b1, 8'(k*4), 1'b0, 32'(1) << k);
    end
    apply("R5 bit29", 1'b1, 8'h14, 1'b0, 32'h2000_0000);
    apply("R10 sec hi", 1'b1, 8'h1C, 1'b1, 32'h8000_0000);
  endtask

  task automatic t_unowned_R6();
    apply("R6 0x00 sec", 1'b1, 8'h00, 1'b1, 32'hFFFF_FFFF);
    apply("R6 0x14 sec", 1'b1, 8'h14, 1'b1, 32'hFFFF_FFFF);
    apply("R6 0x00 ns", 1'b1, 8'h00, 1'b0, 32'hFFFF_FFFF);
    apply("R6 0x14 ns", 1'b1, 8'h14, 1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic t_bad_offset_R7();
    logic [7:0] bad [5] = '{8'h05, 8'h0A, 8'h1F, 8'h20, 8'hFC};
    foreach (bad[i]) apply("R7", 1'b1, bad[i], i[0], 32'hFFFF_FFFF);
  endtask

  task automatic t_no_strobe_R8();
    apply("R8 sec", 1'b0, 8'h08, 1'b1, 32'hFFFF_FFFF);
    apply("R8 ns", 1'b0, 8'h1C, 1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic t_hold_R9();
    apply("R9 set", 1'b1, 8'h0C, 1'b1, 32'h0000_0008);
    apply("R9 miss", 1'b1, 8'h18, 1'b1, 32'h0000_0008);
    check("R9 held sec", vec_s, 3);
    apply("R9 idle", 1'b0, 8'h1C, 1'b1, 32'hFFFF_FFFF);
  endtask

  initial begin
    t_reset_R1();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_pulse_R2();
    t_secure_map_R3_R4();
    t_nonsecure_R5_R10();
    t_unowned_R6();
    t_bad_offset_R7();
    t_no_strobe_R8();
    t_hold_R9();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule